// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Unit

This block holds the single atomic reservation of a 32-bit core. The pipeline presents one memory-access event per accepted request: a kind code, a base register value, a signed 16-bit displacement and store data. The block forms the effective address itself. It remembers whether a reservation is armed and which address armed it. It decides whether a conditional store may reach memory, and it drives the memory write port for both conditional and ordinary stores.

A linked load arms the reservation. A conditional store succeeds only against a matching, still-armed reservation, and every conditional store disarms it. Ordinary stores that land on the reserved word also disarm it. The outcome of each conditional store is written into the core's condition flag, which later conditional branches read. All results appear on registered outputs one clock after the request is accepted.

Top module: `llsc_reservation_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, no response or write is produced, `req_ready` is 0 and `cond_flag` is 0. The reservation starts disarmed, so a conditional store with no linked load before it fails.
- R2: Kind 0 is a linked load and kind 1 is a conditional store. A conditional store succeeds only if the reservation is armed and its effective address equals the recorded address in all 32 bits. Success is reported on `sc_ok`.
- R3: `cond_flag` takes the outcome of each conditional store (1 for success, 0 for failure). It keeps its value across every other kind of request and across idle cycles.
- R4: A conditional store writes memory only when it succeeds. The write uses all four byte strobes, the store data unmodified, and the effective address.
- R5: Every conditional store disarms the reservation, whether it succeeds or fails.
- R6: Kinds 2, 3 and 4 are plain word, halfword and byte stores. Each one disarms the reservation when its effective address ANDed with 0x0FFFFFFC equals the recorded address. Otherwise the reservation is left as it was, so a reservation whose address has any of bits 31..28 or 1..0 set is never cancelled by a plain store.
- R7: The effective address is the base plus the sign-extended displacement, wrapping modulo 2^32.
- R8: Plain stores always write. Byte lane k holds address bits [1:0]=k. A word store asserts strobes 1111 with the data as given. A halfword store asserts 0011 or 1100 as selected by address bit 1, with data[15:0] placed in both halves. A byte store asserts only lane address[1:0], with data[7:0] placed in every lane.
- R9: A second linked load replaces the recorded address and leaves the reservation armed.
- R10: `req_ready` is 1 from the second cycle after reset is released. Every accepted request (`req_valid` and `req_ready` both 1 at a clock edge) yields `rsp_valid` for exactly the following cycle, and no response appears without an accepted request.
- R11: Kind codes 5, 6 and 7 are accepted and answered. They do not write memory and leave both the reservation and `cond_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | Access kind code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_data | input | 32 | Store data |
| rsp_valid | output | 1 | One-cycle response for an accepted request |
| mem_we | output | 1 | Memory write enable |
| mem_strb | output | 4 | Byte strobes of the write |
| mem_addr | output | 32 | Effective address of the accepted request |
| mem_wdata | output | 32 | Write data, lane-replicated for sub-word stores |
| sc_ok | output | 1 | Conditional store succeeded |
| cond_flag | output | 1 | Processor condition flag |

## Verification
The assertions check the following on every cycle:
- The handshake pairs each accepted request with exactly one response one cycle later.
- Any successful conditional store carries a full-word write that coincides with a response.
- The condition flag moves only after a conditional store, and success is never reported unless a linked load has armed the reservation since the last conditional store.
- Outputs are quiet right after reset.

Other behaviours need the bench's scenarios: a reservation whose address was overwritten by a second linked load, cancellation by plain stores, and the masked comparison that lets stores to high or unaligned reserved addresses leave the reservation armed. Showing these takes a sequence of requests and a model that remembers the reserved address.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  localparam int KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    ACC_LINK_LOAD  = 3'd0,
    ACC_COND_STORE = 3'd1,
    ACC_STORE_W    = 3'd2,
    ACC_STORE_H    = 3'd3,
    ACC_STORE_B    = 3'd4
  } acc_kind_e;

endpackage

// File: rtl/llsc_addr_gen.sv
// Effective address, byte strobes and lane-replicated write data.
module llsc_addr_gen
  import llsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0]   base,
  input  logic [OFF_W-1:0]    offset,
  input  logic [KIND_W-1:0]   kind,
  input  logic [DATA_W-1:0]   data,
  output logic [ADDR_W-1:0]   ea,
  output logic [DATA_W/8-1:0] strb,
  output logic [DATA_W-1:0]   wdata
);
  localparam int STRB_W    = DATA_W / 8;
  localparam int LANE_BITS = $clog2(STRB_W);

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  assign ea = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};

  for (genvar g = 0; g < STRB_W; g++) begin : g_lane
    assign byte_rep[g*8 +: 8] = data[7:0];
    assign half_rep[g*8 +: 8] = data[(g%2)*8 +: 8];
  end

  always_comb begin
    strb  = '0;
    wdata = data;
    case (kind)
      ACC_COND_STORE,
      ACC_STORE_W: strb = '1;
      ACC_STORE_H: begin
        strb  = {{(STRB_W-2){1'b0}}, 2'b11} << {ea[LANE_BITS-1:1], 1'b0};
        wdata = half_rep;
      end
      ACC_STORE_B: begin
        strb  = {{(STRB_W-1){1'b0}}, 1'b1} << ea[LANE_BITS-1:0];
        wdata = byte_rep;
      end
      default: strb = '0;
    endcase
  end

endmodule

// File: rtl/llsc_resv_track.sv
// Reservation flag and address, with the commit decision.
module llsc_resv_track
  import llsc_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] CANCEL_MASK = 32'h0FFF_FFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [KIND_W-1:0] kind,
  input  logic [ADDR_W-1:0] ea,
  output logic              sc_pass
);
  logic              armed_q;
  logic [ADDR_W-1:0] resv_addr_q;
  logic              plain_hit;

  assign sc_pass   = armed_q && (ea == resv_addr_q);
  assign plain_hit = armed_q && ((ea & CANCEL_MASK) == resv_addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q     <= 1'b0;
      resv_addr_q <= '0;
    end else if (accept) begin
      case (kind)
        ACC_LINK_LOAD: begin
          armed_q     <= 1'b1;
          resv_addr_q <= ea;
        end
        ACC_COND_STORE: armed_q <= 1'b0;
        ACC_STORE_W,
        ACC_STORE_H,
        ACC_STORE_B: if (plain_hit) armed_q <= 1'b0;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/llsc_reservation_unit.sv
module llsc_reservation_unit
  import llsc_pkg::*;
#(
  parameter int               ADDR_W      = 32,
  parameter int               DATA_W      = 32,
  parameter int               OFF_W       = 16,
  parameter logic [ADDR_W-1:0] CANCEL_MASK = 32'h0FFF_FFFC
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [KIND_W-1:0]   req_kind,
  input  logic [ADDR_W-1:0]   req_base,
  input  logic [OFF_W-1:0]    req_offset,
  input  logic [DATA_W-1:0]   req_data,
  output logic                rsp_valid,
  output logic                mem_we,
  output logic [DATA_W/8-1:0] mem_strb,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                sc_ok,
  output logic                cond_flag
);
  localparam int STRB_W = DATA_W / 8;

  logic              accept;
  logic [ADDR_W-1:0] ea;
  logic [STRB_W-1:0] strb;
  logic [DATA_W-1:0] wdata;
  logic              sc_pass;
  logic              is_sc;
  logic              is_plain;
  logic              do_write;

  assign accept   = req_valid && req_ready;
  assign is_sc    = (req_kind == ACC_COND_STORE);
  assign is_plain = (req_kind == ACC_STORE_W) || (req_kind == ACC_STORE_H) ||
                    (req_kind == ACC_STORE_B);
  assign do_write = accept && (is_plain || (is_sc && sc_pass));

  llsc_addr_gen #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OFF_W  (OFF_W)
  ) u_addr_gen (
    .base   (req_base),
    .offset (req_offset),
    .kind   (req_kind),
    .data   (req_data),
    .ea     (ea),
    .strb   (strb),
    .wdata  (wdata)
  );

  llsc_resv_track #(
    .ADDR_W      (ADDR_W),
    .CANCEL_MASK (CANCEL_MASK)
  ) u_resv (
    .clk     (clk),
    .rst     (rst),
    .accept  (accept),
    .kind    (req_kind),
    .ea      (ea),
    .sc_pass (sc_pass)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      mem_we    <= 1'b0;
      mem_strb  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      sc_ok     <= 1'b0;
      cond_flag <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      mem_we    <= do_write;
      mem_strb  <= do_write ? strb : '0;
      sc_ok     <= accept && is_sc && sc_pass;
      if (accept) begin
        mem_addr  <= ea;
        mem_wdata <= wdata;
      end
      if (accept && is_sc) cond_flag <= sc_pass;
    end
  end

endmodule

// File: rtl/llsc_reservation_unit_chk.sv
module llsc_reservation_unit_chk
  import llsc_pkg::*;
#(
  parameter int STRB_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [KIND_W-1:0] req_kind,
  input logic              rsp_valid,
  input logic              mem_we,
  input logic [STRB_W-1:0] mem_strb,
  input logic              sc_ok,
  input logic              cond_flag
);
  logic armed_seen;

  always_ff @(posedge clk) begin
    if (rst) armed_seen <= 1'b0;
    else if (req_valid && req_ready) begin
      if (req_kind == ACC_LINK_LOAD)       armed_seen <= 1'b1;
      else if (req_kind == ACC_COND_STORE) armed_seen <= 1'b0;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && !mem_we && !cond_flag && !sc_ok));

  assert_sc_needs_link_R2: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> $past(armed_seen));

  assert_flag_moves_only_on_sc_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(req_valid && req_ready && (req_kind == ACC_COND_STORE)) |-> $stable(cond_flag));

  assert_sc_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> cond_flag);

  assert_sc_full_word_R4: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> (mem_we && (mem_strb == {STRB_W{1'b1}})));

  assert_write_has_rsp_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> rsp_valid);

  assert_rsp_from_accept_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && req_ready));

  assert_accept_gives_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

endmodule

bind llsc_reservation_unit llsc_reservation_unit_chk #(.STRB_W(DATA_W/8)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_kind  (req_kind),
  .rsp_valid (rsp_valid),
  .mem_we    (mem_we),
  .mem_strb  (mem_strb),
  .sc_ok     (sc_ok),
  .cond_flag (cond_flag)
);

// File: tb/tb_llsc_reservation_unit.sv
`timescale 1ns/1ps
module tb_llsc_reservation_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = 3'd0;
  logic [31:0] req_base = 32'd0;
  logic [15:0] req_offset = 16'd0;
  logic [31:0] req_data = 32'd0;
  logic        rsp_valid, mem_we, sc_ok, cond_flag;
  logic [3:0]  mem_strb;
  logic [31:0] mem_addr, mem_wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit seen_edge = 0;

  always #2.5 clk = ~clk;

  llsc_reservation_unit dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_base(req_base), .req_offset(req_offset),
    .req_data(req_data), .rsp_valid(rsp_valid), .mem_we(mem_we),
    .mem_strb(mem_strb), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .sc_ok(sc_ok), .cond_flag(cond_flag)
  );

  // Behavioural reference model
  bit          m_ready, m_armed;
  logic [31:0] m_resv;
  bit          e_rsp, e_we, e_sc, e_cond;
  logic [3:0]  e_strb;
  logic [31:0] e_addr, e_wdata;

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      m_ready = 0; m_armed = 0; m_resv = 0;
      e_rsp = 0; e_we = 0; e_sc = 0; e_cond = 0; e_strb = 0;
    end else begin
      automatic bit acc = req_valid && m_ready;
      automatic logic [31:0] ea = req_base + {{16{req_offset[15]}}, req_offset};
      e_rsp = acc; e_we = 0; e_sc = 0; e_strb = 0;
      if (acc) begin
        e_addr = ea;
        case (req_kind)
          3'd0: begin m_armed = 1; m_resv = ea; end
          3'd1: begin
            e_sc = m_armed && (ea == m_resv);
            e_cond = e_sc;
            m_armed = 0;
            if (e_sc) begin e_we = 1; e_strb = 4'hF; e_wdata = req_data; end
          end
          3'd2, 3'd3, 3'd4: begin
            if (m_armed && ((ea & 32'h0FFF_FFFC) == m_resv)) m_armed = 0;
            e_we = 1;
            if (req_kind == 3'd2) begin e_strb = 4'hF; e_wdata = req_data; end
            else if (req_kind == 3'd3) begin
              e_strb = (ea % 4 >= 2) ? 4'b1100 : 4'b0011;
              e_wdata = {req_data[15:0], req_data[15:0]};
            end else begin
              e_strb = 4'(1 << (ea % 4));
              e_wdata = {4{req_data[7:0]}};
            end
          end
          default: ;
        endcase
      end
      m_ready = 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (seen_edge) begin
      if (rst) begin
        chk("R1 rsp_valid in reset", 32'(rsp_valid), 0);
        chk("R1 req_ready in reset", 32'(req_ready), 0);
        chk("R1 cond_flag in reset", 32'(cond_flag), 0);
      end else begin
        chk("R10 req_ready", 32'(req_ready), 32'(m_ready));
        chk("R10 rsp_valid", 32'(rsp_valid), 32'(e_rsp));
        chk("R4 mem_we", 32'(mem_we), 32'(e_we));
        chk("R2 sc_ok", 32'(sc_ok), 32'(e_sc));
        chk("R3 cond_flag", 32'(cond_flag), 32'(e_cond));
        if (e_we) begin
          chk("R8 mem_strb", 32'(mem_strb), 32'(e_strb));
          chk("R7 mem_addr", mem_addr, e_addr);
          chk("R8 mem_wdata", mem_wdata, e_wdata);
        end
      end
    end
  end

  task automatic issue(input logic [2:0] k, input logic [31:0] ea, input logic [15:0] off,
                       input logic [31:0] d);
    req_valid = 1; req_kind = k; req_offset = off; req_data = d;
    req_base = ea - {{16{off[15]}}, off};
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic sc_expect(input logic [31:0] ea, input bit exp, input string tag);
    issue(3'd1, ea, 16'h0010, 32'hCAFE_0000 ^ ea);
    chk(tag, 32'(sc_ok), 32'(exp));
    chk({tag, " cond_flag"}, 32'(cond_flag), 32'(exp));
  endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary_and_end();
  end

  initial begin
    logic [31:0] pool [6];
    pool = '{32'h0000_0100, 32'h0000_0101, 32'h0000_0103,
             32'h0000_0104, 32'h1000_0100, 32'h0000_0102};
    repeat (4) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);

    // R1: conditional store with no linked load fails
    sc_expect(32'h0000_0100, 0, "R1 sc without link");

    // R2/R7: link then matching store, negative offset
    issue(3'd0, 32'h0000_0100, 16'hFF80, 0);
    sc_expect(32'h0000_0100, 1, "R2 matching sc");
    chk("R4 sc write strobes", 32'(mem_strb), 32'hF);
    // R5: second sc after success fails
    sc_expect(32'h0000_0100, 0, "R5 sc after success");

    // R5: mismatch fails and still disarms
    issue(3'd0, 32'h0000_2000, 16'h0004, 0);
    sc_expect(32'h0000_2004, 0, "R2 address mismatch");
    sc_expect(32'h0000_2000, 0, "R5 disarmed by failed sc");

    // R9: second link replaces address
    issue(3'd0, 32'h0000_3000, 16'h0000, 0);
    issue(3'd0, 32'h0000_4000, 16'h0000, 0);
    sc_expect(32'h0000_3000, 0, "R9 old address lost");
    issue(3'd0, 32'h0000_3000, 16'h0000, 0);
    issue(3'd0, 32'h0000_4000, 16'h0000, 0);
    sc_expect(32'h0000_4000, 1, "R9 new address armed");

    // R6/R8: plain stores to the reserved word cancel
    issue(3'd0, 32'h0000_0500, 16'h0000, 0);
    issue(3'd4, 32'h0000_0503, 16'h0001, 32'h0000_00A5);
    chk("R8 byte strobe", 32'(mem_strb), 32'h8);
    chk("R8 byte data", mem_wdata, 32'hA5A5_A5A5);
    sc_expect(32'h0000_0500, 0, "R6 byte store cancels");
    issue(3'd0, 32'h0000_0500, 16'h0000, 0);
    issue(3'd3, 32'h0000_0502, 16'h0000, 32'h0000_BEEF);
    chk("R8 half strobe", 32'(mem_strb), 32'hC);
    chk("R8 half data", mem_wdata, 32'hBEEF_BEEF);
    sc_expect(32'h0000_0500, 0, "R6 half store cancels");
    issue(3'd0, 32'h0000_0500, 16'h0000, 0);
    issue(3'd2, 32'h0000_0504, 16'h0000, 32'h1234_5678);
    sc_expect(32'h0000_0500, 1, "R6 other word keeps reservation");

    // R6: masked compare quirks
    issue(3'd0, 32'h1000_0100, 16'h0000, 0);
    issue(3'd2, 32'h1000_0100, 16'h0000, 32'h1);
    sc_expect(32'h1000_0100, 1, "R6 high-nibble address survives");
    issue(3'd0, 32'h0000_0102, 16'h0000, 0);
    issue(3'd2, 32'h0000_0102, 16'h0000, 32'h2);
    sc_expect(32'h0000_0102, 1, "R6 unaligned reservation survives");

    // R11: unused kinds have no effect
    issue(3'd0, 32'h0000_0600, 16'h0000, 0);
    issue(3'd6, 32'h0000_0600, 16'h0000, 32'h3);
    chk("R11 no write", 32'(mem_we), 0);
    chk("R11 flag held", 32'(cond_flag), 1);
    issue(3'd7, 32'h0000_0600, 16'h0000, 32'h3);
    sc_expect(32'h0000_0600, 1, "R11 reservation kept");

    // R7: wrap-around address
    issue(3'd2, 32'hFFFF_FFFC, 16'hFFF8, 32'h5);
    chk("R7 wrapped address", mem_addr, 32'hFFFF_FFFC);

    // Mixed stream, model compared on every clock
    for (int i = 0; i < 600; i++) begin
      automatic logic [2:0] k = ($urandom % 3 == 0) ? 3'd0 : 3'($urandom % 8);
      automatic logic [31:0] a = pool[$urandom % 6];
      if ($urandom % 4 == 0) @(negedge clk);
      else issue(k, a, 16'($urandom), $urandom);
    end
    repeat (3) @(negedge clk);
    summary_and_end();
  end

endmodule